// File: doc/BRIEF.md
# Multicycle Core Sequencing Controller

This block is the main control state machine of a multicycle 32-bit core that runs a small load/store instruction subset. It takes the 6-bit opcode held in the instruction register and steps the shared datapath (one memory, one ALU, one register file) through a fetch step, a decode step and one to three execute steps per instruction. Every output depends on the current state alone.

The ALU is shared across steps. During fetch it produces PC+4. During decode, when no other step needs it, it forms the branch target. A branch therefore finishes in three cycles, and no instruction needs more than five. The function decoder that turns the ALU operation code and funct field into an ALU control word lives outside this block, and so does the datapath.

Top module: `mc_main_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the outputs show the fetch state: pc_write_o=1, ir_write_o=1, alu_src_b_o=01, all other outputs 0.
- R2: Fetch drives iord_o=0 (address from PC), alu_src_a_o=0 (PC), alu_src_b_o=01 (constant 4), alu_op_o=00 (add) and pc_src_o=00 (direct ALU result), with both pc_write_o and ir_write_o set. After the last step of any instruction, the next cycle is fetch.
- R3: Decode follows fetch. It asserts no write strobe and drives alu_src_a_o=0 and alu_src_b_o=11 (sign-extended immediate shifted left by two), with alu_op_o=00.
- R4: A load (opcode 100011) takes 5 cycles. The address step drives alu_src_a_o=1 (register A) and alu_src_b_o=10 (sign-extended immediate) with add. The read step drives iord_o=1. The writeback step drives reg_write_o=1, reg_dst_o=0 (rt) and mem_to_reg_o=1.
- R5: A store (opcode 101011) takes 4 cycles: the same address step, then one step with mem_write_o=1 and iord_o=1.
- R6: A register-register instruction (opcode 000000) takes 4 cycles: one step with alu_src_a_o=1, alu_src_b_o=00 (register B) and alu_op_o=10 (use funct), then one step with reg_write_o=1, reg_dst_o=1 (rd) and mem_to_reg_o=0.
- R7: An add-immediate (opcode 001000) takes 4 cycles: one step with alu_src_a_o=1, alu_src_b_o=10 and add, then one step with reg_write_o=1, reg_dst_o=0 and mem_to_reg_o=0.
- R8: A branch-if-equal (opcode 000100) takes 3 cycles. Its last step drives branch_o=1, alu_op_o=01 (subtract), alu_src_a_o=1, alu_src_b_o=00 and pc_src_o=01 (registered ALU output), with pc_write_o=0.
- R9: A jump (opcode 000010) takes 3 cycles. Its last step drives pc_write_o=1 and pc_src_o=10 (jump target).
- R10: Any other opcode returns to fetch straight after decode, so the instruction takes 2 cycles and asserts no write strobe beyond those of fetch.
- R11: At most one of mem_write_o, reg_write_o and ir_write_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| pc_write_o | output | 1 | Unconditional PC load |
| mem_write_o | output | 1 | Memory write strobe |
| ir_write_o | output | 1 | Instruction register load |
| reg_write_o | output | 1 | Register file write strobe |
| iord_o | output | 1 | Memory address source: 0 PC, 1 ALU output register |
| alu_src_a_o | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_src_b_o | output | 2 | ALU B operand: 00 reg B, 01 four, 10 immediate, 11 immediate<<2 |
| alu_op_o | output | 2 | 00 add, 01 subtract, 10 use funct |
| pc_src_o | output | 2 | Next PC: 00 ALU result, 01 ALU output register, 10 jump target |
| reg_dst_o | output | 1 | Write register: 0 rt, 1 rd |
| mem_to_reg_o | output | 1 | Write data: 0 ALU output register, 1 memory data |
| branch_o | output | 1 | Conditional PC load when the ALU result is zero |

## Verification
Fetch loads the instruction register and writes the incremented PC in the same cycle. The bench judges that cycle as one output word, so losing either strobe, or pointing pc_src_o or alu_src_b_o away from the increment path, shows up as a mismatch. The same check runs at the start of every instruction in the vector table, including straight after a three-cycle branch or jump and after a reset pulse in the middle of a load. Latency is also measured independently as the spacing between instruction-register loads.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LW   = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_SW   = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_RTYP = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_J    = 6'b000010;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_MEM_ADR, S_MEM_RD, S_MEM_WB, S_MEM_WR,
    S_EXEC, S_ALU_WB, S_BRANCH, S_ADDI_EX, S_ADDI_WB, S_JUMP
  } state_e;

  typedef enum logic [1:0] {SRCB_REG = 2'b00, SRCB_FOUR = 2'b01,
                            SRCB_IMM = 2'b10, SRCB_IMM_SH = 2'b11} srcb_e;
  typedef enum logic [1:0] {AOP_ADD = 2'b00, AOP_SUB = 2'b01,
                            AOP_FUNCT = 2'b10} aluop_e;
  typedef enum logic [1:0] {PCS_ALU = 2'b00, PCS_ALUOUT = 2'b01,
                            PCS_JUMP = 2'b10} pcsrc_e;

  typedef struct packed {
    logic       pc_write;
    logic       mem_write;
    logic       ir_write;
    logic       reg_write;
    logic       iord;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       branch;
  } ctrl_t;
endpackage

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_e           state_i,
  input  logic [OPC_W-1:0] opcode_i,
  output state_e           next_o
);
  always_comb begin
    next_o = S_FETCH;
    unique case (state_i)
      S_FETCH:  next_o = S_DECODE;
      S_DECODE: begin
        case (opcode_i)
          OPC_LW, OPC_SW: next_o = S_MEM_ADR;
          OPC_RTYP:       next_o = S_EXEC;
          OPC_BEQ:        next_o = S_BRANCH;
          OPC_ADDI:       next_o = S_ADDI_EX;
          OPC_J:          next_o = S_JUMP;
          default:        next_o = S_FETCH;  // unsupported: drop quietly
        endcase
      end
      S_MEM_ADR: next_o = (opcode_i == OPC_SW) ? S_MEM_WR : S_MEM_RD;
      S_MEM_RD:  next_o = S_MEM_WB;
      S_EXEC:    next_o = S_ALU_WB;
      S_ADDI_EX: next_o = S_ADDI_WB;
      default:   next_o = S_FETCH;   // every terminal step
    endcase
  end
endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      S_FETCH: begin
        ctrl_o.ir_write  = 1'b1;
        ctrl_o.pc_write  = 1'b1;
        ctrl_o.alu_src_b = SRCB_FOUR;
      end
      S_DECODE: ctrl_o.alu_src_b = SRCB_IMM_SH;  // speculative branch target
      S_MEM_ADR, S_ADDI_EX: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_src_b = SRCB_IMM;
      end
      S_MEM_RD: ctrl_o.iord = 1'b1;
      S_MEM_WB: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      S_MEM_WR: begin
        ctrl_o.iord      = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      S_EXEC: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_op    = AOP_FUNCT;
      end
      S_ALU_WB: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.reg_dst   = 1'b1;
      end
      S_BRANCH: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_op    = AOP_SUB;
        ctrl_o.pc_src    = PCS_ALUOUT;
        ctrl_o.branch    = 1'b1;
      end
      S_ADDI_WB: ctrl_o.reg_write = 1'b1;
      S_JUMP: begin
        ctrl_o.pc_write = 1'b1;
        ctrl_o.pc_src   = PCS_JUMP;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_main_ctrl.sv
module mc_main_ctrl
  import mc_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             pc_write_o,
  output logic             mem_write_o,
  output logic             ir_write_o,
  output logic             reg_write_o,
  output logic             iord_o,
  output logic             alu_src_a_o,
  output logic [1:0]       alu_src_b_o,
  output logic [1:0]       alu_op_o,
  output logic [1:0]       pc_src_o,
  output logic             reg_dst_o,
  output logic             mem_to_reg_o,
  output logic             branch_o
);
  state_e state_q, state_d;
  ctrl_t  ctrl;

  mc_next_state i_next (.state_i(state_q), .opcode_i(opcode_i), .next_o(state_d));
  mc_out_decode i_outs (.state_i(state_q), .ctrl_o(ctrl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH;
    else         state_q <= state_d;
  end

  assign pc_write_o   = ctrl.pc_write;
  assign mem_write_o  = ctrl.mem_write;
  assign ir_write_o   = ctrl.ir_write;
  assign reg_write_o  = ctrl.reg_write;
  assign iord_o       = ctrl.iord;
  assign alu_src_a_o  = ctrl.alu_src_a;
  assign alu_src_b_o  = ctrl.alu_src_b;
  assign alu_op_o     = ctrl.alu_op;
  assign pc_src_o     = ctrl.pc_src;
  assign reg_dst_o    = ctrl.reg_dst;
  assign mem_to_reg_o = ctrl.mem_to_reg;
  assign branch_o     = ctrl.branch;

  logic known_opc;
  assign known_opc = opcode_i inside {OPC_LW, OPC_SW, OPC_RTYP, OPC_BEQ, OPC_ADDI, OPC_J};

  p_fetch_to_decode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_write_o |=> (!ir_write_o && !pc_write_o && !reg_write_o && !mem_write_o
                    && alu_src_b_o == 2'b11));

  p_branch_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o |=> ir_write_o);

  p_jump_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_write_o && pc_src_o == 2'b10) |=> ir_write_o);

  p_load_wb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_write_o && mem_to_reg_o) |-> ($past(iord_o) && !$past(mem_write_o)));

  p_unknown_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DECODE && !known_opc) |=> ir_write_o);

  p_one_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_write_o, reg_write_o, ir_write_o}));
endmodule

// File: tb/test_mc_main_ctrl.sv
module test_mc_main_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  localparam int MAXL = 5;

  // word: pcw memw irw regw iord srca srcb[2] aluop[2] pcsrc[2] regdst m2r br
  localparam logic [14:0] W_FETCH = 15'b1_0_1_0_0_0_01_00_00_0_0_0;
  localparam logic [14:0] W_DEC   = 15'b0_0_0_0_0_0_11_00_00_0_0_0;
  localparam logic [14:0] W_ADR   = 15'b0_0_0_0_0_1_10_00_00_0_0_0;
  localparam logic [14:0] W_RD    = 15'b0_0_0_0_1_0_00_00_00_0_0_0;
  localparam logic [14:0] W_LWB   = 15'b0_0_0_1_0_0_00_00_00_0_1_0;
  localparam logic [14:0] W_WR    = 15'b0_1_0_0_1_0_00_00_00_0_0_0;
  localparam logic [14:0] W_EXE   = 15'b0_0_0_0_0_1_00_10_00_0_0_0;
  localparam logic [14:0] W_RWB   = 15'b0_0_0_1_0_0_00_00_00_1_0_0;
  localparam logic [14:0] W_BR    = 15'b0_0_0_0_0_1_00_01_01_0_0_1;
  localparam logic [14:0] W_IWB   = 15'b0_0_0_1_0_0_00_00_00_0_0_0;
  localparam logic [14:0] W_JMP   = 15'b1_0_0_0_0_0_00_00_10_0_0_0;
  localparam logic [14:0] W_NONE  = 15'b0;

  localparam logic [5:0] V_OPC [NV] = '{6'b100011, 6'b101011, 6'b000000, 6'b000100,
                                        6'b001000, 6'b000010, 6'b111111, 6'b000100,
                                        6'b100011};
  localparam int V_LEN [NV] = '{5, 4, 4, 3, 4, 3, 2, 3, 5};
  localparam logic [14:0] V_EXP [NV*MAXL] = '{
    W_FETCH, W_DEC, W_ADR, W_RD,  W_LWB,   // R4 load
    W_FETCH, W_DEC, W_ADR, W_WR,  W_NONE,  // R5 store
    W_FETCH, W_DEC, W_EXE, W_RWB, W_NONE,  // R6 register op
    W_FETCH, W_DEC, W_BR,  W_NONE, W_NONE, // R8 branch
    W_FETCH, W_DEC, W_ADR, W_IWB, W_NONE,  // R7 add-immediate
    W_FETCH, W_DEC, W_JMP, W_NONE, W_NONE, // R9 jump
    W_FETCH, W_DEC, W_NONE, W_NONE, W_NONE,// R10 unknown
    W_FETCH, W_DEC, W_BR,  W_NONE, W_NONE, // R8 then R4 back-to-back
    W_FETCH, W_DEC, W_ADR, W_RD,  W_LWB};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [5:0] opcode_i = '0;
  logic pc_write_o, mem_write_o, ir_write_o, reg_write_o, iord_o, alu_src_a_o;
  logic [1:0] alu_src_b_o, alu_op_o, pc_src_o;
  logic reg_dst_o, mem_to_reg_o, branch_o;
  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mc_main_ctrl i_mc_main_ctrl (
    .clk_i, .rst_ni, .opcode_i, .pc_write_o, .mem_write_o, .ir_write_o,
    .reg_write_o, .iord_o, .alu_src_a_o, .alu_src_b_o, .alu_op_o, .pc_src_o,
    .reg_dst_o, .mem_to_reg_o, .branch_o);

  logic [14:0] obs;
  assign obs = {pc_write_o, mem_write_o, ir_write_o, reg_write_o, iord_o, alu_src_a_o,
                alu_src_b_o, alu_op_o, pc_src_o, reg_dst_o, mem_to_reg_o, branch_o};

  function automatic string tag_of(logic [5:0] opc);
    case (opc)
      6'b100011: return "R4";
      6'b101011: return "R5";
      6'b000000: return "R6";
      6'b001000: return "R7";
      6'b000100: return "R8";
      6'b000010: return "R9";
      default:   return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [14:0] act, logic [14:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    int gap;
    @(negedge clk_i);
    check("R1", obs, W_FETCH);
    @(negedge clk_i);
    check("R1", obs, W_FETCH);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      opcode_i = V_OPC[i];
      for (int k = 0; k < V_LEN[i]; k++) begin
        // k==0 is the fetch cycle: PC increment and IR load together (R2)
        check((k == 0) ? "R2" : (k == 1) ? "R3" : tag_of(V_OPC[i]),
              obs, V_EXP[i*MAXL+k]);
        @(negedge clk_i);
      end
    end
    check("R2", obs, W_FETCH);

    // R1: reset in the middle of a load read step
    opcode_i = 6'b100011;
    repeat (3) @(negedge clk_i);
    check("R4", obs, W_RD);
    rst_ni = 1'b0;
    #1;
    check("R1", obs, W_FETCH);
    @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1", obs, W_FETCH);
    @(negedge clk_i);
    check("R3", obs, W_DEC);
    @(negedge clk_i);
    check("R4", obs, W_ADR);
    repeat (3) @(negedge clk_i);
    check("R2", obs, W_FETCH);

    // R6: latency as spacing of IR loads
    opcode_i = 6'b000000;
    gap = 0;
    do begin
      @(negedge clk_i);
      gap++;
    end while (!ir_write_o && gap < 10);
    n_checks++;
    if (gap != 4) begin
      n_err++;
      $display("FAIL R6 latency act=%0d exp=4", gap);
    end

    // R10: another unsupported opcode (000011), 2 cycles, no extra writes
    opcode_i = 6'b000011;
    @(negedge clk_i);
    check("R10", obs, W_DEC);
    @(negedge clk_i);
    check("R10", obs, W_FETCH);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule